// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

This block is the countdown timer that sits beside a local interrupt controller. Software programs it through a small register window. A control entry holds the interrupt vector, a mask flag and a repeat flag. A 4-bit code selects the clock ratio. Writing a start value arms the count, and a live count register can be read back at any time. The counter steps down once for every selected number of bus clocks. When it reaches zero, the block emits a one-cycle interrupt request that carries the vector, unless the mask flag is set.

In repeat mode the counter refills itself from the last start value and runs again. In single mode it stays at zero until software writes a new start value. Delivery and priority handling of the request belong to the surrounding controller. This block only produces the pulse and the vector.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset the control entry reads 0x0001_0000 (masked, single mode, vector 0). The ratio code and the live count both read 0, and `irq_pulse` is low.
- R2: The ratio code is decoded from bits {3,1,0} of the written value, and bit 2 is ignored. The codes 0xB, 0x0, 0x1, 0x2, 0x3, 0x8, 0x9 and 0xA give ratios 1, 2, 4, 8, 16, 32, 64 and 128. For example, 0x4 acts as 0x0 and 0xF acts as 0xB.
- R3: Writing a non-zero start value N arms the count. After the k-th clock edge that follows the write edge, the live count equals N - floor(k/ratio), and it stops at 0. The first request appears in the cycle after edge N*ratio.
- R4: Each request is exactly one cycle high. `irq_vector` carries control-entry bits 7:0 during that cycle.
- R5: In single mode (control bit 17 clear), the live count holds at 0 after expiry and no further request is raised.
- R6: In repeat mode (control bit 17 set), the count is refilled with N on the edge after it reaches zero. Requests repeat every N*ratio+1 cycles.
- R7: Control bit 16 set suppresses the request. It does not stop the count, the refill, or the live-count readback.
- R8: Writing a start value of 0 stops the timer at once, and no request follows.
- R9: A write to the ratio code restarts the prescaler. A step already due on that same edge still happens, and the following steps come every new-ratio cycles.
- R10: Register select 0 is the control entry, 1 the ratio code, 2 the start value and 3 the live count. Reads return data one cycle after the select is presented. The start value reads 0, writes to the live count have no effect, and control bits other than 17, 16 and 7:0 read 0.
- R11: Writing a new start value while counting restarts the count from the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register select for the read |
| rd_data | output | 32 | Registered read data, one cycle after `rd_sel` |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector that accompanies `irq_pulse` |

## Verification
Almost all internal state reaches the live-count register, so a wrong prescaler phase or a missed step shows up on `rd_data` within one prescaler period. That lag is one cycle plus the read latency. A lost refill or a wrongly retained running flag shows up as a missing or extra request within one period, N*ratio+1 cycles. For that reason the bench checks the live count on every cycle of a countdown at every ratio. It also checks the exact cycle of every request against the arithmetic schedule.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  typedef enum logic [1:0] {
    SEL_ENTRY = 2'd0,
    SEL_DIV   = 2'd1,
    SEL_INIT  = 2'd2,
    SEL_CUR   = 2'd3
  } reg_sel_e;

  localparam int ENTRY_MASK_BIT = 16;
  localparam int ENTRY_REP_BIT  = 17;

  // ratio = 2**shift; bits {3,1,0} plus one, wrapping, give the shift
  function automatic logic [2:0] div_shift(input logic [3:0] code);
    logic [2:0] s;
    s = {code[3], code[1:0]};
    return s + 3'd1;
  endfunction

endpackage

// File: rtl/cdt_regs.sv
module cdt_regs #(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [VEC_W-1:0]  vec_q,
  output logic              mask_q,
  output logic              rep_q,
  output logic [3:0]        div_code_q,
  output logic              div_wr,
  output logic              arm
);
  import cdt_pkg::*;

  logic unused_bits;
  assign unused_bits = ^wr_data;

  assign div_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_DIV);
  assign arm    = wr_en && (reg_sel_e'(wr_sel) == SEL_INIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q      <= '0;
      mask_q     <= 1'b1;
      rep_q      <= 1'b0;
      div_code_q <= 4'h0;
    end else begin
      if (wr_en && reg_sel_e'(wr_sel) == SEL_ENTRY) begin
        vec_q  <= wr_data[VEC_W-1:0];
        mask_q <= wr_data[ENTRY_MASK_BIT];
        rep_q  <= wr_data[ENTRY_REP_BIT];
      end
      if (div_wr) div_code_q <= wr_data[3:0];
    end
  end

  // R1: first cycle after reset shows the masked default
  p_reset_mask_r1: assert property (@(posedge clk) $fell(rst) |-> mask_q);

endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SHIFT_W-1:0] shift,
  input  logic               restart,
  output logic               tick
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] lim;

  always_comb begin
    lim  = PRE_W'((32'd1 << shift) - 32'd1);
    tick = (cnt == lim);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  // R9: a restart puts the prescaler back to phase zero
  p_restart_phase_r9: assert property (@(posedge clk) disable iff (rst)
    restart |=> cnt == '0);

  // R2: the phase never passes the limit of a steady ratio
  p_phase_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (!restart && $stable(shift) && cnt <= lim) |=> cnt <= lim);

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic [CNT_W-1:0] arm_val,
  input  logic             tick,
  input  logic             rep,
  input  logic             mask,
  input  logic [VEC_W-1:0] vec,
  output logic [CNT_W-1:0] cur,
  output logic             reload_pend,
  output logic             irq_q,
  output logic [VEC_W-1:0] irq_vec_q
);
  logic [CNT_W-1:0] init_q;
  logic             running;
  logic             hit;

  assign hit = running && !reload_pend && tick && (cur == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q      <= '0;
      cur         <= '0;
      running     <= 1'b0;
      reload_pend <= 1'b0;
      irq_q       <= 1'b0;
      irq_vec_q   <= '0;
    end else begin
      irq_q <= 1'b0;
      if (arm) begin
        init_q      <= arm_val;
        cur         <= arm_val;
        running     <= (arm_val != '0);
        reload_pend <= 1'b0;
      end else if (reload_pend) begin
        cur         <= init_q;
        reload_pend <= 1'b0;
      end else if (running && tick) begin
        cur <= cur - 1'b1;
        if (hit) begin
          running     <= rep;
          reload_pend <= rep;
          irq_q       <= !mask;
          irq_vec_q   <= vec;
        end
      end
    end
  end

  // R5: an idle counter keeps its value
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (!running && !arm && !reload_pend) |=> $stable(cur));

  // R3: one step down per prescaler tick
  p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
    (running && tick && !arm && !reload_pend && cur != '0) |=> cur == $past(cur) - 1'b1);

  // R6: refill lands on the edge after zero
  p_refill_r6: assert property (@(posedge clk) disable iff (rst)
    (reload_pend && !arm) |=> cur == init_q);

  // R4: request is a single cycle
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);

  // R7: a masked entry never yields a request
  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> !$past(mask));

  // R8: arming with zero leaves the counter idle
  p_zero_stop_r8: assert property (@(posedge clk) disable iff (rst)
    (arm && arm_val == '0) |=> (cur == '0 && !running));

endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer #(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 32,
  parameter int VEC_W   = 8,
  parameter int SHIFT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_pulse,
  output logic [VEC_W-1:0]  irq_vector
);
  import cdt_pkg::*;

  logic [VEC_W-1:0]   vec_q;
  logic               mask_q;
  logic               rep_q;
  logic [3:0]         div_code_q;
  logic               div_wr;
  logic               arm;
  logic               tick;
  logic [CNT_W-1:0]   cur;
  logic               reload_pend;
  logic [SHIFT_W-1:0] shift;
  logic [DATA_W-1:0]  entry_word;

  assign shift = SHIFT_W'(div_shift(div_code_q));

  cdt_regs #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .vec_q(vec_q), .mask_q(mask_q), .rep_q(rep_q), .div_code_q(div_code_q),
    .div_wr(div_wr), .arm(arm)
  );

  cdt_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
    .clk(clk), .rst(rst), .shift(shift),
    .restart(div_wr || arm || reload_pend), .tick(tick)
  );

  cdt_counter #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_cnt (
    .clk(clk), .rst(rst), .arm(arm), .arm_val(wr_data[CNT_W-1:0]),
    .tick(tick), .rep(rep_q), .mask(mask_q), .vec(vec_q),
    .cur(cur), .reload_pend(reload_pend),
    .irq_q(irq_pulse), .irq_vec_q(irq_vector)
  );

  always_comb begin
    entry_word                 = '0;
    entry_word[VEC_W-1:0]      = vec_q;
    entry_word[ENTRY_MASK_BIT] = mask_q;
    entry_word[ENTRY_REP_BIT]  = rep_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (reg_sel_e'(rd_sel))
        SEL_ENTRY: rd_data <= entry_word;
        SEL_DIV:   rd_data <= DATA_W'(div_code_q);
        SEL_INIT:  rd_data <= '0;
        default:   rd_data <= DATA_W'(cur);
      endcase
    end
  end

  // R10: the start value is never visible on the read port
  p_init_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_sel_e'(rd_sel) == SEL_INIT) |=> rd_data == '0);

endmodule

// File: tb/test_irq_countdown_timer.sv
`timescale 1ns/1ps
module test_irq_countdown_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd3;
  logic [31:0] rd_data;
  logic        irq_pulse;
  logic [7:0]  irq_vector;

  int checks = 0;
  int errors = 0;
  int first, npulse;
  int pos[8];
  logic [31:0] cap_a, cap_b;

  always #2.5 clk = ~clk;

  irq_countdown_timer i_irq_countdown_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_pulse(irq_pulse), .irq_vector(irq_vector)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    rd_sel = sel;
    @(negedge clk);
    v = rd_data;
    rd_sel = 2'd3;
  endtask

  // k counts edges after the last write edge
  task automatic window(input int len, input logic [7:0] ev, input int n,
                        input int ratio, input bit ccur);
    first = -1; npulse = 0;
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      if (irq_pulse) begin
        if (npulse < 8) pos[npulse] = k;
        npulse++;
        if (first < 0) first = k;
        check("R4 vector", {24'd0, irq_vector}, {24'd0, ev});
      end
      if (k == 5)  cap_a = rd_data;
      if (k == 16) cap_b = rd_data;
      if (ccur) begin
        int q;
        q = (k - 1) / ratio;
        check("R3 live count", rd_data, (q >= n) ? 32'd0 : 32'(n - q));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int codes[8] = '{32'hB, 32'h0, 32'h1, 32'h2, 32'h3, 32'h8, 32'h9, 32'hA};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {31'd0, irq_pulse}, 32'd0);
    rd(2'd0, v); check("R1 entry", v, 32'h0001_0000);
    rd(2'd1, v); check("R1 div", v, 32'd0);
    rd(2'd3, v); check("R1 count", v, 32'd0);

    // R2 R3 R4 R5 every ratio, single mode, full live-count sweep
    for (int i = 0; i < 8; i++) begin
      int ratio;
      ratio = 1 << i;
      wr(2'd0, 32'h40 + i);
      wr(2'd1, codes[i]);
      wr(2'd2, 32'd3);
      window(3 * ratio + 20, 8'(32'h40 + i), 3, ratio, 1'b1);
      check("R2 R3 first request", first, 3 * ratio);
      check("R5 one request", npulse, 1);
    end

    // R2 bit 2 ignored
    wr(2'd0, 32'h11);
    wr(2'd1, 32'h4); wr(2'd2, 32'd5);
    window(30, 8'h11, 5, 2, 1'b1);
    check("R2 code 0x4", first, 10);
    wr(2'd1, 32'hF); wr(2'd2, 32'd5);
    window(30, 8'h11, 5, 1, 1'b1);
    check("R2 code 0xF", first, 5);

    // R6 repeat mode, period N*ratio+1
    wr(2'd0, 32'h0002_0021);
    wr(2'd1, 32'h0);
    wr(2'd2, 32'd4);
    window(30, 8'h21, 4, 2, 1'b0);
    check("R6 pulses", npulse, 3);
    check("R6 first", pos[0], 8);
    check("R6 second", pos[1], 17);
    check("R6 third", pos[2], 26);

    // R8 zero start value stops a running repeat timer
    wr(2'd2, 32'd6);
    repeat (3) @(negedge clk);
    wr(2'd2, 32'd0);
    window(40, 8'h21, 0, 1, 1'b0);
    check("R8 no request", npulse, 0);
    rd(2'd3, v); check("R8 count", v, 32'd0);

    // R7 masked repeat keeps counting and refilling
    wr(2'd0, 32'h0003_0022);
    wr(2'd1, 32'hB);
    wr(2'd2, 32'd10);
    window(30, 8'h22, 0, 1, 1'b0);
    check("R7 no request", npulse, 0);
    check("R7 count moves", cap_a, 32'd6);
    check("R7 refill", cap_b, 32'd6);
    wr(2'd2, 32'd0);

    // R9 ratio change mid-count
    wr(2'd0, 32'h23);
    wr(2'd1, 32'hB);
    wr(2'd2, 32'd20);
    repeat (4) @(negedge clk);
    wr(2'd1, 32'h1);
    window(80, 8'h23, 0, 1, 1'b0);
    check("R9 first", first, 60);
    check("R9 pulses", npulse, 1);

    // R11 re-arm while running
    wr(2'd1, 32'hB);
    wr(2'd2, 32'd50);
    repeat (10) @(negedge clk);
    wr(2'd2, 32'd3);
    window(60, 8'h23, 0, 1, 1'b0);
    check("R11 first", first, 3);
    check("R11 pulses", npulse, 1);

    // R10 register port rules
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); check("R10 entry fields", v, 32'h0003_00FF);
    wr(2'd0, 32'h24);
    wr(2'd2, 32'd40);
    wr(2'd3, 32'd5);
    rd(2'd2, v); check("R10 init reads zero", v, 32'd0);
    window(60, 8'h24, 0, 1, 1'b0);
    check("R10 count write ignored", first, 38);
    check("R10 pulses", npulse, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule